// File: doc/BRIEF.md
# Maskable Interrupt Controller with Software Triggers

This block gathers up to 32 interrupt sources and presents them to a processor as two request lines: a normal request and a fast request. Each source is the OR of a hardware input line and a software-settable trigger bit. A per-source enable bit masks the source. A per-source steering bit then sends it to one of the two request lines. Software reaches the block through a simple single-cycle register port. On that port it reads three views of the sources: unmasked, masked towards the normal line, and masked towards the fast line.

Enables and software triggers each have two write addresses, one that sets bits and one that clears them. A read-modify-write is therefore never needed to change a single source. A protection bit lets privileged code lock the register port against accesses made in user mode. While the lock holds, user writes are dropped and user reads return zero. Reads return data combinationally in the cycle of the access. Writes take effect at the clock edge that ends the access.

Top module: `intc_mask_top`

## Requirements
- R1: After reset the enable, steering, software-trigger and protection state is all zero, so both request outputs are low and every readable address returns zero.
- R2: A read of byte offset 0x08 returns the raw source word, the bitwise OR of the hardware lines and the software-trigger bits, with no masking.
- R3: A read of offset 0x00 returns raw AND enable AND NOT steering. The output `irq_o` is high exactly when this word is non-zero.
- R4: A read of offset 0x04 returns raw AND enable AND steering. The output `fiq_o` is high exactly when this word is non-zero.
- R5: A write to offset 0x10 sets every enable bit that is 1 in the write data and leaves the others unchanged. A read of 0x10 returns the enable word.
- R6: A write to offset 0x14 clears every enable bit that is 1 in the write data. A read of 0x14 returns zero.
- R7: A write to offset 0x18 sets every software-trigger bit that is 1 in the write data. A read of 0x18 returns the software-trigger word.
- R8: A write to offset 0x1C clears every software-trigger bit that is 1 in the write data. A read of 0x1C returns zero.
- R9: A write to offset 0x0C replaces the steering word, where bit n = 1 sends source n to the fast line. A read of 0x0C returns it.
- R10: Bit 0 of offset 0x20 is the protection bit, and a read of 0x20 returns it in bit 0. While it is 1, an access with `acc_user_i` high changes no state and reads zero. Privileged accesses are never blocked.
- R11: Any other offset, including one that is not word aligned, reads zero, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_src_i | input | 32 | Hardware interrupt lines, active high, level sensitive |
| acc_en_i | input | 1 | Register access valid this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 6 | Byte offset of the register |
| acc_wdata_i | input | 32 | Write data |
| acc_user_i | input | 1 | Access is made from user mode |
| acc_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A wrong enable, steering or trigger bit appears on `irq_o`/`fiq_o` in the first cycle after the faulty write, provided the matching source is active. It also appears on the next read of the affected register or status word. The stimulus therefore keeps hardware lines active while the masks change, so a stale or misrouted bit becomes visible at once and is not hidden. A protection fault appears either as non-zero read data for a user access or as a state change that a later privileged read exposes.

// File: rtl/intc_mask_pkg.sv
package intc_mask_pkg;

    localparam int N_SRC  = 32;
    localparam int ADDR_W = 6;

    typedef logic [N_SRC-1:0]  src_vec_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t OFF_IRQ_STAT = 6'h00;
    localparam addr_t OFF_FIQ_STAT = 6'h04;
    localparam addr_t OFF_RAW      = 6'h08;
    localparam addr_t OFF_STEER    = 6'h0C;
    localparam addr_t OFF_EN_SET   = 6'h10;
    localparam addr_t OFF_EN_CLR   = 6'h14;
    localparam addr_t OFF_SW_SET   = 6'h18;
    localparam addr_t OFF_SW_CLR   = 6'h1C;
    localparam addr_t OFF_LOCK     = 6'h20;

    typedef struct packed {
        src_vec_t steer;
        src_vec_t en;
        src_vec_t sw;
        logic     lock;
    } ctl_state_t;

endpackage

// File: rtl/intc_mask_regs.sv
module intc_mask_regs
    import intc_mask_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ok,
    input  addr_t      addr,
    input  src_vec_t   wdata,
    output ctl_state_t st_q
);

    ctl_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (addr)
                OFF_STEER:  st_d.steer = wdata;
                OFF_EN_SET: st_d.en    = st_q.en | wdata;
                OFF_EN_CLR: st_d.en    = st_q.en & ~wdata;
                OFF_SW_SET: st_d.sw    = st_q.sw | wdata;
                OFF_SW_CLR: st_d.sw    = st_q.sw & ~wdata;
                OFF_LOCK:   st_d.lock  = wdata[0];
                default:    st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/intc_mask_route.sv
module intc_mask_route
    import intc_mask_pkg::*;
#(
    parameter int NUM = N_SRC
)
(
    input  logic [NUM-1:0] hw,
    input  logic [NUM-1:0] sw,
    input  logic [NUM-1:0] en,
    input  logic [NUM-1:0] steer,
    output logic [NUM-1:0] raw,
    output logic [NUM-1:0] irq_stat,
    output logic [NUM-1:0] fiq_stat,
    output logic           any_irq,
    output logic           any_fiq
);

    for (genvar g = 0; g < NUM; g++) begin : g_src
        logic live;
        assign live        = hw[g] | sw[g];
        assign raw[g]      = live;
        assign irq_stat[g] = live & en[g] & ~steer[g];
        assign fiq_stat[g] = live & en[g] & steer[g];
    end

    assign any_irq = |irq_stat;
    assign any_fiq = |fiq_stat;

endmodule

// File: rtl/intc_mask_rdmux.sv
module intc_mask_rdmux
    import intc_mask_pkg::*;
(
    input  logic       rd_ok,
    input  addr_t      addr,
    input  ctl_state_t st,
    input  src_vec_t   raw,
    input  src_vec_t   irq_stat,
    input  src_vec_t   fiq_stat,
    output src_vec_t   rdata
);

    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            case (addr)
                OFF_IRQ_STAT: rdata = irq_stat;
                OFF_FIQ_STAT: rdata = fiq_stat;
                OFF_RAW:      rdata = raw;
                OFF_STEER:    rdata = st.steer;
                OFF_EN_SET:   rdata = st.en;
                OFF_SW_SET:   rdata = st.sw;
                OFF_LOCK:     rdata = {{(N_SRC-1){1'b0}}, st.lock};
                default:      rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/intc_mask_top.sv
module intc_mask_top
    import intc_mask_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] hw_src_i,
    input  logic        acc_en_i,
    input  logic        acc_wr_i,
    input  logic [5:0]  acc_addr_i,
    input  logic [31:0] acc_wdata_i,
    input  logic        acc_user_i,
    output logic [31:0] acc_rdata_o,
    output logic        irq_o,
    output logic        fiq_o
);

    ctl_state_t st_q;
    logic       permit;
    logic       wr_ok;
    logic       rd_ok;
    src_vec_t   raw;
    src_vec_t   irq_stat;
    src_vec_t   fiq_stat;

    assign permit = acc_en_i & ~(st_q.lock & acc_user_i);
    assign wr_ok  = permit & acc_wr_i;
    assign rd_ok  = permit & ~acc_wr_i;

    intc_mask_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (wr_ok),
        .addr  (acc_addr_i),
        .wdata (acc_wdata_i),
        .st_q  (st_q)
    );

    intc_mask_route #(.NUM(N_SRC)) u_route (
        .hw       (hw_src_i),
        .sw       (st_q.sw),
        .en       (st_q.en),
        .steer    (st_q.steer),
        .raw      (raw),
        .irq_stat (irq_stat),
        .fiq_stat (fiq_stat),
        .any_irq  (irq_o),
        .any_fiq  (fiq_o)
    );

    intc_mask_rdmux u_rdmux (
        .rd_ok    (rd_ok),
        .addr     (acc_addr_i),
        .st       (st_q),
        .raw      (raw),
        .irq_stat (irq_stat),
        .fiq_stat (fiq_stat),
        .rdata    (acc_rdata_o)
    );

endmodule

// File: rtl/intc_mask_chk.sv
module intc_mask_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] hw,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [5:0]  acc_addr,
    input logic [31:0] acc_wdata,
    input logic        acc_user,
    input logic [31:0] acc_rdata,
    input logic        irq,
    input logic        fiq,
    input logic [31:0] en_q,
    input logic [31:0] steer_q,
    input logic [31:0] sw_q,
    input logic        lock_q
);

    logic allowed;
    assign allowed = acc_en && !(lock_q && acc_user);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && steer_q == '0 && sw_q == '0 && !lock_q));

    p_raw_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (allowed && !acc_wr && acc_addr == 6'h08) |-> (acc_rdata == (hw | sw_q)));

    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (!irq && !fiq));

    p_fiq_needs_steer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_q == '0) |-> !fiq);

    p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (allowed && acc_wr && acc_addr == 6'h10)
        |=> ((en_q & $past(acc_wdata)) == $past(acc_wdata)));

    p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (allowed && acc_wr && acc_addr == 6'h14) |=> ((en_q & $past(acc_wdata)) == '0));

    p_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (allowed && acc_wr && acc_addr == 6'h18)
        |=> ((sw_q & $past(acc_wdata)) == $past(acc_wdata)));

    p_sw_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (allowed && acc_wr && acc_addr == 6'h1C) |=> ((sw_q & $past(acc_wdata)) == '0));

    p_locked_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_user && lock_q) |-> (acc_rdata == '0));

    p_locked_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_user && lock_q)
        |=> ($stable(en_q) && $stable(steer_q) && $stable(sw_q) && $stable(lock_q)));

endmodule

bind intc_mask_top intc_mask_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw        (hw_src_i),
    .acc_en    (acc_en_i),
    .acc_wr    (acc_wr_i),
    .acc_addr  (acc_addr_i),
    .acc_wdata (acc_wdata_i),
    .acc_user  (acc_user_i),
    .acc_rdata (acc_rdata_o),
    .irq       (irq_o),
    .fiq       (fiq_o),
    .en_q      (st_q.en),
    .steer_q   (st_q.steer),
    .sw_q      (st_q.sw),
    .lock_q    (st_q.lock)
);

// File: tb/intc_mask_top_tb_top.sv
module intc_mask_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw_src_i = '0;
    logic        acc_en_i = 1'b0;
    logic        acc_wr_i = 1'b0;
    logic [5:0]  acc_addr_i = '0;
    logic [31:0] acc_wdata_i = '0;
    logic        acc_user_i = 1'b0;
    logic [31:0] acc_rdata_o;
    logic        irq_o;
    logic        fiq_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    logic [31:0] m_en = '0, m_steer = '0, m_sw = '0;
    logic        m_lock = 1'b0;

    always #2 clk = ~clk;

    intc_mask_top dut_i (
        .clk(clk), .rst_n(rst_n), .hw_src_i(hw_src_i),
        .acc_en_i(acc_en_i), .acc_wr_i(acc_wr_i), .acc_addr_i(acc_addr_i),
        .acc_wdata_i(acc_wdata_i), .acc_user_i(acc_user_i),
        .acc_rdata_o(acc_rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic string addr_tag(input logic [5:0] a);
        case (a)
            6'h00: return "R3";
            6'h04: return "R4";
            6'h08: return "R2";
            6'h0C: return "R9";
            6'h10: return "R5";
            6'h14: return "R6";
            6'h18: return "R7";
            6'h1C: return "R8";
            6'h20: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] a, input logic [31:0] hw, input bit user);
        logic [31:0] rw;
        rw = hw | m_sw;
        if (m_lock && user) return '0;
        case (a)
            6'h00: return rw & m_en & ~m_steer;
            6'h04: return rw & m_en & m_steer;
            6'h08: return rw;
            6'h0C: return m_steer;
            6'h10: return m_en;
            6'h18: return m_sw;
            6'h20: return {31'd0, m_lock};
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, compare before posedge, update model after it
    task automatic cyc(input bit en, input bit wr, input logic [5:0] a,
                       input logic [31:0] d, input bit user, input logic [31:0] hw,
                       input string tag = "");
        logic [31:0] rw;
        @(negedge clk);
        acc_en_i = en; acc_wr_i = wr; acc_addr_i = a; acc_wdata_i = d;
        acc_user_i = user; hw_src_i = hw;
        #1;
        rw = hw | m_sw;
        check("R3 irq_o", {31'd0, irq_o}, {31'd0, |(rw & m_en & ~m_steer)});
        check("R4 fiq_o", {31'd0, fiq_o}, {31'd0, |(rw & m_en & m_steer)});
        if (en && !wr)
            check(tag == "" ? ((m_lock && user) ? "R10" : addr_tag(a)) : tag,
                  acc_rdata_o, model_read(a, hw, user));
        @(posedge clk);
        if (en && wr && !(m_lock && user)) begin
            case (a)
                6'h0C: m_steer = d;
                6'h10: m_en    = m_en | d;
                6'h14: m_en    = m_en & ~d;
                6'h18: m_sw    = m_sw | d;
                6'h1C: m_sw    = m_sw & ~d;
                6'h20: m_lock  = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic rd(input logic [5:0] a, input bit user, input logic [31:0] hw, input string tag = "");
        cyc(1'b1, 1'b0, a, '0, user, hw, tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input bit user, input logic [31:0] hw);
        cyc(1'b1, 1'b1, a, d, user, hw);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible at every readable offset
        for (int a = 0; a <= 'h24; a += 4) rd(6'(a), 1'b0, 32'h0, "R1");
        rd(6'h08, 1'b0, 32'hA5A5_0003);                        // R2 raw = hw only
        // R5: set semantics, zeros leave bits alone
        wr(6'h10, 32'h0000_00FF, 1'b0, 32'h0);
        wr(6'h10, 32'h0000_0F00, 1'b0, 32'h0);
        rd(6'h10, 1'b0, 32'h0);
        rd(6'h00, 1'b0, 32'h0000_0113);                        // R3
        rd(6'h08, 1'b0, 32'h0000_0113);                        // R2
        // R9/R4: steer source 1 to fast line
        wr(6'h0C, 32'h0000_0002, 1'b0, 32'h0000_0013);
        rd(6'h0C, 1'b0, 32'h0000_0013);
        rd(6'h04, 1'b0, 32'h0000_0013);
        rd(6'h00, 1'b0, 32'h0000_0013);
        // R6: clear-enable, write-only
        wr(6'h14, 32'h0000_0013, 1'b0, 32'h0000_0013);
        rd(6'h10, 1'b0, 32'h0000_0013);
        rd(6'h14, 1'b0, 32'h0000_0013);
        // R7/R8: software triggers
        wr(6'h18, 32'h8000_0100, 1'b0, 32'h0);
        rd(6'h18, 1'b0, 32'h0);
        rd(6'h08, 1'b0, 32'h0000_0004);
        rd(6'h00, 1'b0, 32'h0);
        wr(6'h1C, 32'h0000_0100, 1'b0, 32'h0);
        rd(6'h18, 1'b0, 32'h0);
        rd(6'h1C, 1'b0, 32'h0);
        // R11: unmapped and unaligned offsets
        wr(6'h28, 32'hFFFF_FFFF, 1'b0, 32'h0);
        wr(6'h11, 32'hFFFF_FFFF, 1'b0, 32'h0);
        rd(6'h24, 1'b0, 32'hFFFF_FFFF);
        rd(6'h02, 1'b0, 32'hFFFF_FFFF);
        rd(6'h10, 1'b0, 32'h0, "R11");
        // R10: protection
        wr(6'h20, 32'h0000_0001, 1'b0, 32'h0);
        rd(6'h20, 1'b0, 32'h0);
        wr(6'h10, 32'hFFFF_0000, 1'b1, 32'h0);
        wr(6'h20, 32'h0000_0000, 1'b1, 32'h0);
        rd(6'h10, 1'b1, 32'h0);
        rd(6'h10, 1'b0, 32'h0, "R10");
        rd(6'h20, 1'b0, 32'h0, "R10");
        wr(6'h20, 32'h0000_0000, 1'b0, 32'h0);
        wr(6'h10, 32'h00F0_0000, 1'b1, 32'h0);
        rd(6'h10, 1'b1, 32'h0);
        // mixed traffic
        lf = 32'h1D87_2B41;
        for (int i = 0; i < 400; i++) begin
            logic [5:0] a;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case (lf[3:0])
                4'd0, 4'd1: a = 6'h10;
                4'd2:       a = 6'h14;
                4'd3:       a = 6'h18;
                4'd4:       a = 6'h1C;
                4'd5:       a = 6'h0C;
                4'd6:       a = 6'h20;
                4'd7:       a = 6'h00;
                4'd8:       a = 6'h04;
                4'd9:       a = 6'h08;
                4'd10:      a = 6'h2C;
                default:    a = {lf[7:4], 2'b00};
            endcase
            cyc(lf[9] | lf[10], lf[11], a, {lf[15:0], lf[31:16]} & {lf[31:16], lf[15:0]},
                lf[12] & lf[13], lf & {lf[7:0], lf[31:8]});
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule